// File: doc/BRIEF.md
# Sparse Row Stream Encoder

This block takes a small square matrix held in an internal register array and turns it into a compressed stream of its non-zero elements. The array is filled one element at a time through a load port while the block is idle. A start pulse then launches a scan in row-major order, one element per cycle. Each non-zero element leaves as one record on a valid/ready stream. A record holds the element value, its column number and a chain flag.

The chain flag is set when another non-zero follows later in the same row, and it is clear on the last non-zero of a row. A downstream row-wise consumer, for example a matrix-by-vector accumulator, can therefore close a row without a separate length field. Each record is kept back by one element of lookahead until its chain flag is known.

Alongside the stream, the block writes a row-offset table through a write-only port. Entry r gives the position in the record sequence of row r's first record. One further entry, N, gives the total record count. A one-cycle completion pulse marks the end of the job.

Top module: `sparse_row_encoder`

## Requirements
- R1: After reset, rec_valid, ptr_we, done and busy are all 0.
- R2: Records leave in row-major order (row 0 first, columns ascending within a row), one record per non-zero element and none for a zero element, each carrying the element value and its column number.
- R3: rec_chain is 1 on every record of a row except that row's last non-zero, where it is 0.
- R4: A row with exactly one non-zero produces one record with rec_chain 0.
- R5: For each row r in 0..N-1, one write with ptr_idx = r carries the number of records that precede that row's first record. A row without non-zeros emits no record, and its entry equals the entry of the next row.
- R6: One write with ptr_idx = N carries the total number of non-zero elements.
- R7: While rec_valid is 1 and rec_ready is 0, rec_valid stays 1 and rec_value, rec_col and rec_chain hold their values; the scan stalls until the record is taken.
- R8: done is a single-cycle pulse that comes exactly once per job. It is asserted after the final record has been accepted and the final table entry has been written.
- R9: ld_en and start have no effect while busy is 1. A matrix load attempted during a job leaves the stored matrix unchanged.
- R10: An all-zero matrix emits no record, writes 0 to all N+1 table entries and still ends with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one matrix element (idle only) |
| ld_row | input | $clog2(N) | Row of the element being loaded |
| ld_col | input | $clog2(N) | Column of the element being loaded |
| ld_data | input | DW | Element value |
| start | input | 1 | Begin a job (idle only) |
| busy | output | 1 | Job in progress |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_value | output | DW | Non-zero element value |
| rec_col | output | $clog2(N) | Column of the element |
| rec_chain | output | 1 | Another non-zero follows in the same row |
| ptr_we | output | 1 | Row-offset table write strobe |
| ptr_idx | output | $clog2(N+1) | Table entry index, 0..N |
| ptr_val | output | $clog2(N*N+1) | Record offset written to the entry |
| done | output | 1 | One-cycle job completion pulse |

## Verification
The bench builds the block with N = 4 and an 8-bit element width. With these values each matrix has only 16 elements, so a run can contain the edge patterns directly: an empty matrix, a full matrix, single-entry rows, rows with no entries between filled rows, and a non-zero in the last column. A 4×4 matrix also lets many seeded random matrices at several densities finish quickly. Throughout, rec_ready is toggled at random, so the hold and stall behaviour is tested in every row position, including the flush step at the end of a row and the last record of a job.

// File: rtl/sparse_row_encoder.sv
module sparse_row_encoder #(
  parameter int N  = 4,
  parameter int DW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_en,
  input  logic [$clog2(N)-1:0]       ld_row,
  input  logic [$clog2(N)-1:0]       ld_col,
  input  logic [DW-1:0]              ld_data,
  input  logic                       start,
  output logic                       busy,
  output logic                       rec_valid,
  input  logic                       rec_ready,
  output logic [DW-1:0]              rec_value,
  output logic [$clog2(N)-1:0]       rec_col,
  output logic                       rec_chain,
  output logic                       ptr_we,
  output logic [$clog2(N+1)-1:0]     ptr_idx,
  output logic [$clog2(N*N+1)-1:0]   ptr_val,
  output logic                       done
);
  localparam int CW = $clog2(N);
  localparam int AW = $clog2(N*N);
  localparam int IW = $clog2(N+1);
  localparam int PW = $clog2(N*N+1);
  localparam logic [CW-1:0] LAST = CW'(N-1);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_FLUSH, S_FINAL, S_DRAIN} phase_t;

  phase_t          phase;
  logic [DW-1:0]   mat [N*N];
  logic [CW-1:0]   r, c;
  logic [PW-1:0]   cnt;
  logic            pend_v;
  logic [DW-1:0]   pend_val;
  logic [CW-1:0]   pend_col;

  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] elem;
  logic          out_free;

  assign rd_addr  = AW'(r) * AW'(N) + AW'(c);
  assign wr_addr  = AW'(ld_row) * AW'(N) + AW'(ld_col);
  assign elem     = mat[rd_addr];
  assign out_free = !rec_valid || rec_ready;
  assign busy     = phase != S_IDLE;

  always_ff @(posedge clk)
    if (phase == S_IDLE && ld_en) mat[wr_addr] <= ld_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= S_IDLE;
      r         <= '0;
      c         <= '0;
      cnt       <= '0;
      pend_v    <= 1'b0;
      pend_val  <= '0;
      pend_col  <= '0;
      rec_valid <= 1'b0;
      rec_value <= '0;
      rec_col   <= '0;
      rec_chain <= 1'b0;
      ptr_we    <= 1'b0;
      ptr_idx   <= '0;
      ptr_val   <= '0;
      done      <= 1'b0;
    end else begin
      ptr_we <= 1'b0;
      done   <= 1'b0;
      if (out_free) rec_valid <= 1'b0;
      case (phase)
        S_IDLE: if (start) begin
          r      <= '0;
          c      <= '0;
          cnt    <= '0;
          pend_v <= 1'b0;
          phase  <= S_SCAN;
        end
        S_SCAN: if (out_free) begin
          if (c == '0) begin
            ptr_we  <= 1'b1;
            ptr_idx <= IW'(r);
            ptr_val <= cnt;
          end
          if (elem != '0) begin
            cnt <= cnt + 1'b1;
            if (pend_v) begin
              rec_valid <= 1'b1;
              rec_value <= pend_val;
              rec_col   <= pend_col;
              rec_chain <= 1'b1;
            end
            pend_v   <= 1'b1;
            pend_val <= elem;
            pend_col <= c;
          end
          if (c == LAST) phase <= S_FLUSH;
          else           c     <= c + 1'b1;
        end
        S_FLUSH: if (out_free) begin
          if (pend_v) begin
            rec_valid <= 1'b1;
            rec_value <= pend_val;
            rec_col   <= pend_col;
            rec_chain <= 1'b0;
            pend_v    <= 1'b0;
          end
          if (r == LAST) phase <= S_FINAL;
          else begin
            r     <= r + 1'b1;
            c     <= '0;
            phase <= S_SCAN;
          end
        end
        S_FINAL: begin
          ptr_we  <= 1'b1;
          ptr_idx <= IW'(N);
          ptr_val <= cnt;
          phase   <= S_DRAIN;
        end
        S_DRAIN: if (out_free) begin
          done  <= 1'b1;
          phase <= S_IDLE;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  logic [PW-1:0] acc_cnt, fin_ptr;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      fin_ptr <= '0;
    end else begin
      if (phase == S_IDLE && start) acc_cnt <= '0;
      else if (rec_valid && rec_ready) acc_cnt <= acc_cnt + 1'b1;
      if (ptr_we && ptr_idx == IW'(N)) fin_ptr <= ptr_val;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_value) && $stable(rec_col) && $stable(rec_chain));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rec_valid && !busy);
  assert_total_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> acc_cnt == fin_ptr);
  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |-> ptr_idx <= IW'(N) && ptr_val <= PW'(N*N));
endmodule

// File: tb/sparse_row_encoder_test.sv
`timescale 1ns/1ps
module sparse_row_encoder_test;
  localparam int N = 4;
  localparam int DW = 8;
  localparam int NN = N*N;

  logic clk = 0, rst_n = 0;
  logic ld_en = 0, start = 0, rec_ready = 0;
  logic [1:0] ld_row = 0, ld_col = 0;
  logic [DW-1:0] ld_data = 0;
  logic busy, rec_valid, rec_chain, ptr_we, done;
  logic [DW-1:0] rec_value;
  logic [1:0] rec_col;
  logic [2:0] ptr_idx;
  logic [4:0] ptr_val;

  sparse_row_encoder #(.N(N), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_row(ld_row), .ld_col(ld_col),
    .ld_data(ld_data), .start(start), .busy(busy), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_value(rec_value), .rec_col(rec_col),
    .rec_chain(rec_chain), .ptr_we(ptr_we), .ptr_idx(ptr_idx), .ptr_val(ptr_val),
    .done(done));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  int rdy_pct = 100;

  logic [DW-1:0] m [NN];
  int g_n, g_done;
  logic [DW-1:0] g_val [NN];
  int g_col [NN];
  int g_ch [NN];
  int g_ptr [N+1];
  int g_ptr_w [N+1];
  bit prev_stall;
  logic [DW-1:0] pv; logic [1:0] pc; logic pch;
  int hold_bad, done_wide;
  bit prev_done;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (prev_stall && (!rec_valid || rec_value != pv || rec_col != pc || rec_chain != pch)) hold_bad++;
    prev_stall = rec_valid && !rec_ready;
    pv = rec_value; pc = rec_col; pch = rec_chain;
    if (rec_valid && rec_ready && g_n < NN) begin
      g_val[g_n] = rec_value; g_col[g_n] = int'(rec_col); g_ch[g_n] = int'(rec_chain); g_n++;
    end
    if (ptr_we && ptr_idx <= 3'(N)) begin
      g_ptr[ptr_idx] = int'(ptr_val); g_ptr_w[ptr_idx]++;
    end
    if (done) g_done++;
    if (done && prev_done) done_wide++;
    prev_done = done;
  end

  initial forever begin
    @(posedge clk); #1;
    rec_ready = ($urandom_range(99) < rdy_pct);
  end

  task automatic load_all();
    for (int i = 0; i < NN; i++) begin
      @(posedge clk); #1;
      ld_en = 1; ld_row = 2'(i / N); ld_col = 2'(i % N); ld_data = m[i];
    end
    @(posedge clk); #1; ld_en = 0;
  endtask

  task automatic clear_obs();
    g_n = 0; g_done = 0; hold_bad = 0; done_wide = 0;
    for (int i = 0; i <= N; i++) begin g_ptr[i] = -1; g_ptr_w[i] = 0; end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1; start = 1;
    @(posedge clk); #1; start = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (g_done == 0 && t < 2000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  function automatic bit last_in_row(int i);
    for (int j = i + 1; j < (i / N + 1) * N; j++) if (m[j] != 0) return 0;
    return 1;
  endfunction

  task automatic verify(string tag);
    int e_n = 0, off = 0, bad_rec = 0, bad_ch = 0, bad_one = 0, bad_ptr = 0;
    for (int r = 0; r < N; r++) begin
      int nz = 0;
      chk(g_ptr_w[r] == 1 && g_ptr[r] == off, {"R5 ptr ", tag}, g_ptr[r], off);
      for (int c = 0; c < N; c++) if (m[r*N+c] != 0) nz++;
      for (int c = 0; c < N; c++) begin
        int i = r*N + c;
        if (m[i] != 0) begin
          if (e_n >= g_n || g_val[e_n] != m[i] || g_col[e_n] != c) bad_rec++;
          else if (g_ch[e_n] != int'(!last_in_row(i))) begin
            if (nz == 1) bad_one++; else bad_ch++;
          end
          e_n++;
        end
      end
      off += nz;
    end
    chk(g_n == e_n, {"R2 record count ", tag}, g_n, e_n);
    chk(bad_rec == 0, {"R2 record order/value/column ", tag}, bad_rec, 0);
    chk(bad_ch == 0, {"R3 chain flags ", tag}, bad_ch, 0);
    chk(bad_one == 0, {"R4 single-entry rows ", tag}, bad_one, 0);
    chk(g_ptr_w[N] == 1 && g_ptr[N] == e_n, {"R6 final entry ", tag}, g_ptr[N], e_n);
    chk(g_done == 1 && done_wide == 0, {"R8 done pulse ", tag}, g_done, 1);
    chk(hold_bad == 0, {"R7 hold under backpressure ", tag}, hold_bad, 0);
  endtask

  task automatic run(string tag);
    load_all();
    clear_obs();
    pulse_start();
    wait_done();
    verify(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!rec_valid && !ptr_we && !done && !busy, "R1 reset outputs", int'({rec_valid, ptr_we, done, busy}), 0);
    #1 rst_n = 1;

    for (int i = 0; i < NN; i++) m[i] = 0;
    rdy_pct = 60; run("R10 all-zero");
    for (int i = 0; i <= N; i++) chk(g_ptr[i] == 0, "R10 zero table", g_ptr[i], 0);

    for (int i = 0; i < NN; i++) m[i] = (i / N == i % N) ? DW'(i + 1) : 0;
    rdy_pct = 100; run("identity R4");

    for (int i = 0; i < NN; i++) m[i] = DW'(200 + i);
    rdy_pct = 30; run("full");

    for (int i = 0; i < NN; i++) m[i] = 0;
    m[1] = 9; m[3] = 4; m[15] = 7; m[12] = 5;
    rdy_pct = 50; run("empty middle rows R5");
    chk(g_ptr[1] == g_ptr[2] && g_ptr[2] == g_ptr[3], "R5 empty rows equal next", g_ptr[1], g_ptr[3]);

    for (int t = 0; t < 24; t++) begin
      int dens = (t % 4) * 25 + 15;
      for (int i = 0; i < NN; i++) m[i] = ($urandom_range(99) < dens) ? DW'($urandom_range(255, 1)) : 0;
      rdy_pct = 20 + (t % 5) * 20;
      run($sformatf("random %0d", t));
    end

    for (int i = 0; i < NN; i++) m[i] = (i % 3 == 0) ? DW'(i + 10) : 0;
    rdy_pct = 25;
    load_all();
    clear_obs();
    pulse_start();
    @(posedge clk); #1;
    chk(busy == 1, "R9 busy during job", int'(busy), 1);
    ld_en = 1; ld_row = 0; ld_col = 1; ld_data = 8'hAA; start = 1;
    @(posedge clk); #1; ld_en = 0; start = 0;
    wait_done();
    verify("R9 first run");
    clear_obs();
    pulse_start();
    wait_done();
    verify("R9 rerun without reload");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule